// File: doc/BRIEF.md
# Clock Power-Down Output Gating Controller

This block sits between a clock synthesizer's internal clock sources and its output pins. It stops the outputs cleanly when power-down is requested and brings them back up in a fixed order. One input pin has two roles. After reset it is read as an active-low power-good strobe. When that strobe is first seen low, the three frequency-select straps are captured into a read-only latch. From then on, the same pin is an active-high power-down request.

A power-down request is accepted only when the pin is high on two consecutive rising edges of the reference clock's complement leg. Each output domain then re-synchronizes the request on its own clock and parks on its own falling edge, so no output produces a shortened pulse. Single-ended outputs park low. Each differential group parks in one of two states, chosen by its own drive-mode bit: true leg driven high with the complement leg floating, or both legs floating. Floating is shown through active-high per-leg output enables. The oscillator and PLL stop request is raised only after every domain reports that it has parked.

When the request is removed, the stop request drops, which restarts the PLL. The true leg of every differential group is driven high at once, while all clocks stay parked until the lock flag is seen. After lock, every domain resumes within a few of its own clock periods.

Top module: `clk_pd_gate`

## Requirements
- R1: While rst_n is low, se_out, dt_out, dt_oe, dc_out and dc_oe are all 0, strap_q is 0 and osc_stop is 0.
- R2: The first rising edge of ref_c that sees pd_pin low after reset copies strap_in into strap_q. After that, strap_q does not change until the next reset, whatever strap_in does.
- R3: Before the power-good strobe has been seen low, a high pd_pin is not a power-down request: osc_stop stays 0 and strap_q stays 0.
- R4: A power-down request is accepted only if pd_pin is high on two consecutive rising edges of ref_c. A pin high for a single rising edge has no effect: osc_stop stays 0 and the clocks keep running.
- R5: After acceptance, each se_out[i] is held low from the next falling edge of se_clk_in[i], and no high pulse on se_out[i] is shorter than the high phase of its source.
- R6: After acceptance, differential group g parks on a falling edge of dc_in[g] within 4 periods of dc_in[g], measured from the accepting ref_c edge.
- R7: A parked group g with drive_mode[g]=0 has dt_oe[g]=1, dt_out[g]=1 and dc_oe[g]=0. With drive_mode[g]=1 it has dt_oe[g]=0, dt_out[g]=0 and dc_oe[g]=0.
- R8: osc_stop rises only when every single-ended and differential domain is parked, and it stays high until pd_pin is low again.
- R9: When pd_pin goes low during power-down, osc_stop drops. Until pll_lock is seen high, every group drives its true leg high (dt_oe=1, dt_out=1) with the complement leg floating, and se_out stays 0.
- R10: After pll_lock is high, all single-ended and differential outputs are running again within a few periods of their own clocks (dc_oe and dt_oe at 1, se_out toggling).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_c | input | 1 | Reference clock complement leg; qualifies the request and runs the sequencer |
| pd_pin | input | 1 | Shared pin: active-low power-good strobe first, then active-high power-down request |
| strap_in | input | 3 | Frequency-select strap pins |
| se_clk_in | input | N_SE | Single-ended clock sources |
| dt_in | input | N_DIF | Differential true-leg sources |
| dc_in | input | N_DIF | Differential complement-leg sources; each one clocks its own group |
| drive_mode | input | N_DIF | Per-group parked state: 0 true high and complement floating, 1 both floating |
| pll_lock | input | 1 | PLL lock flag |
| se_out | output | N_SE | Gated single-ended clocks |
| dt_out | output | N_DIF | Gated differential true legs |
| dt_oe | output | N_DIF | True-leg drive enable (0 = floating) |
| dc_out | output | N_DIF | Gated differential complement legs |
| dc_oe | output | N_DIF | Complement-leg drive enable (0 = floating) |
| strap_q | output | 3 | Strap values latched at the power-good strobe |
| osc_stop | output | 1 | Oscillator/PLL stop request; its fall is the restart request |

## Verification
The power-down cycle is run once for each of the four drive-mode combinations of the two differential groups. This tells apart the per-group parked states and shows that one group's mode bit does not leak into the other group. In every cycle the bench measures parking latency against each group's own clock period and checks that the stop request appears only with everything parked. It also checks the early true-leg drive before lock. A one-edge request pulse, which must be ignored, is compared with a two-edge request, which must be accepted. A high pin during the power-good phase, which must not act as power-down, is compared with the later request role. Strap changes after the strobe are checked to leave the latched value untouched.

// File: rtl/clk_pd_gate.sv
module clk_pd_gate #(
  parameter int N_SE  = 2,
  parameter int N_DIF = 2
) (
  input  logic             rst_n,
  input  logic             ref_c,
  input  logic             pd_pin,
  input  logic [2:0]       strap_in,
  input  logic [N_SE-1:0]  se_clk_in,
  input  logic [N_DIF-1:0] dt_in,
  input  logic [N_DIF-1:0] dc_in,
  input  logic [N_DIF-1:0] drive_mode,
  input  logic             pll_lock,
  output logic [N_SE-1:0]  se_out,
  output logic [N_DIF-1:0] dt_out,
  output logic [N_DIF-1:0] dt_oe,
  output logic [N_DIF-1:0] dc_out,
  output logic [N_DIF-1:0] dc_oe,
  output logic [2:0]       strap_q,
  output logic             osc_stop
);

  typedef enum logic [2:0] {S_PG, S_WAKE, S_RUN, S_PARK, S_OFF} st_t;

  st_t st;
  logic pin_q, lk1, lk2, ps1, ps2, ns1, ns2;
  logic [N_SE-1:0]  se_pk;
  logic [N_DIF-1:0] d_pk;

  wire all_pk   = &{se_pk, d_pk};
  wire any_pk   = |{se_pk, d_pk};
  wire pd_two   = pd_pin & pin_q;
  wire park_req = (st != S_RUN);
  wire wake_hi  = (st == S_WAKE);

  assign osc_stop = (st == S_OFF);

  always_ff @(posedge ref_c or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_PG;
      pin_q   <= 1'b0;
      {lk2, lk1} <= 2'b00;
      {ps2, ps1} <= 2'b11;
      {ns2, ns1} <= 2'b11;
      strap_q <= '0;
    end else begin
      pin_q      <= pd_pin;
      {lk2, lk1} <= {lk1, pll_lock};
      {ps2, ps1} <= {ps1, all_pk};
      {ns2, ns1} <= {ns1, any_pk};
      case (st)
        S_PG:   if (!pd_pin) begin
                  strap_q <= strap_in;
                  st      <= S_WAKE;
                end
        S_WAKE: if (pd_two)      st <= S_PARK;
                else if (lk2)    st <= S_RUN;
        S_RUN:  if (pd_two && !ns2) st <= S_PARK;
        S_PARK: if (ps2)         st <= S_OFF;
        S_OFF:  if (!pd_pin)     st <= S_WAKE;
        default:                 st <= S_PG;
      endcase
    end
  end

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    logic s1, s2, pk;
    always_ff @(posedge se_clk_in[i] or negedge rst_n)
      if (!rst_n) {s2, s1} <= 2'b11;
      else        {s2, s1} <= {s1, park_req};
    always_ff @(negedge se_clk_in[i] or negedge rst_n)
      if (!rst_n) pk <= 1'b1;
      else        pk <= s2;
    assign se_pk[i]  = pk;
    assign se_out[i] = se_clk_in[i] & ~pk;
  end

  for (genvar g = 0; g < N_DIF; g++) begin : g_dif
    logic s1, s2, pk;
    always_ff @(posedge dc_in[g] or negedge rst_n)
      if (!rst_n) {s2, s1} <= 2'b11;
      else        {s2, s1} <= {s1, park_req};
    always_ff @(negedge dc_in[g] or negedge rst_n)
      if (!rst_n) pk <= 1'b1;
      else        pk <= s2;
    assign d_pk[g]   = pk;
    assign dt_oe[g]  = rst_n & (~pk | ~drive_mode[g] | wake_hi);
    assign dt_out[g] = rst_n & (pk ? (~drive_mode[g] | wake_hi) : dt_in[g]);
    assign dc_oe[g]  = ~pk;
    assign dc_out[g] = dc_in[g] & ~pk;
  end

  AST_STOP_AFTER_PARK: assert property (@(posedge ref_c) disable iff (!rst_n)
    osc_stop |-> all_pk) else $error("stop raised with a live domain"); // R8

  AST_STRAP_HELD: assert property (@(posedge ref_c) disable iff (!rst_n)
    (st != S_PG) |=> $stable(strap_q)) else $error("strap latch moved"); // R2

  AST_TWO_EDGE_QUAL: assert property (@(posedge ref_c) disable iff (!rst_n)
    (st == S_RUN && !pd_pin) |=> (st != S_PARK)) else $error("request accepted on one edge"); // R4

  AST_PG_NO_STOP: assert property (@(posedge ref_c) disable iff (!rst_n)
    (st == S_PG) |=> !osc_stop) else $error("power-good phase stopped clocks"); // R3

  AST_LOCK_BEFORE_RUN: assert property (@(posedge ref_c) disable iff (!rst_n)
    (st == S_WAKE && !lk2) |=> (st != S_RUN)) else $error("enabled without lock"); // R9

endmodule

// File: tb/clk_pd_gate_test.sv
`timescale 1ns/1ps
module clk_pd_gate_test;

  logic       rst_n = 1'b0;
  logic       ref_c = 1'b0;
  logic       pd_pin = 1'b1;
  logic [2:0] strap_in = 3'b101;
  logic [1:0] se_clk_in = 2'b00;
  logic [1:0] dc_src = 2'b00;
  logic [1:0] drive_mode = 2'b00;
  logic       pll_lock = 1'b0;
  logic [1:0] se_out, dt_out, dt_oe, dc_out, dc_oe;
  logic [2:0] strap_q;
  logic       osc_stop;

  int n_chk = 0, n_fail = 0, runt = 0, r0 = 0, r1 = 0;
  realtime t_acc = 0, t_pk0 = -1, t_pk1 = -1, tr0 = -1, tr1 = -1;

  // [7:6] drive_mode, [5:4] dt_oe, [3:2] dt_out, [1:0] dc_oe while parked
  localparam logic [7:0] VEC [0:3] = '{8'b00_11_11_00, 8'b01_10_10_00,
                                       8'b10_01_01_00, 8'b11_00_00_00};

  clk_pd_gate uut (
    .rst_n(rst_n), .ref_c(ref_c), .pd_pin(pd_pin), .strap_in(strap_in),
    .se_clk_in(se_clk_in), .dt_in(~dc_src), .dc_in(dc_src),
    .drive_mode(drive_mode), .pll_lock(pll_lock),
    .se_out(se_out), .dt_out(dt_out), .dt_oe(dt_oe), .dc_out(dc_out),
    .dc_oe(dc_oe), .strap_q(strap_q), .osc_stop(osc_stop));

  always #10 ref_c = ~ref_c;
  initial begin #3; forever #10 se_clk_in[0] = ~se_clk_in[0]; end
  always #15 se_clk_in[1] = ~se_clk_in[1];
  always #8  dc_src[0] = ~dc_src[0];
  initial begin #5; forever #12 dc_src[1] = ~dc_src[1]; end

  always @(posedge se_out[0]) begin tr0 = $realtime; r0++; end
  always @(posedge se_out[1]) begin tr1 = $realtime; r1++; end
  always @(negedge se_out[0]) if (rst_n && tr0 >= 0 && $realtime - tr0 < 9.9)  runt++;
  always @(negedge se_out[1]) if (rst_n && tr1 >= 0 && $realtime - tr1 < 14.9) runt++;
  always @(negedge dc_oe[0]) t_pk0 = $realtime;
  always @(negedge dc_oe[1]) t_pk1 = $realtime;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_max(input string req, input realtime t, input int lim);
    int lat;
    lat = (t < 0) ? 9999 : int'(t - t_acc);
    n_chk++;
    if (lat > lim) begin
      n_fail++;
      $display("FAIL %s act=%0d exp<=%0d", req, lat, lim);
    end
  endtask

  task automatic wait_stop(input logic val, output int ok);
    ok = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge ref_c);
      if (osc_stop == val) begin ok = 1; return; end
    end
  endtask

  task automatic check_running(input string req);
    repeat (12) @(negedge ref_c);
    chk(req, {dt_oe, dc_oe}, 4'b1111);
    r0 = 0; r1 = 0;
    repeat (4) @(negedge ref_c);
    chk(req, {r0 > 0, r1 > 0}, 2'b11);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int ok;
    repeat (3) @(negedge ref_c);
    // R1 reset state
    chk("R1", {se_out, dt_out, dt_oe, dc_out, dc_oe}, 0);
    chk("R1", {strap_q, osc_stop}, 0);
    rst_n = 1'b1;

    // R3 pin high before the strobe is no request
    repeat (10) @(negedge ref_c);
    chk("R3", osc_stop, 0);
    chk("R3", strap_q, 0);

    // R2 strap capture then hold
    pd_pin = 1'b0;
    repeat (2) @(negedge ref_c);
    chk("R2", strap_q, 3'b101);
    strap_in = 3'b010;
    repeat (5) @(negedge ref_c);
    chk("R2", strap_q, 3'b101);
    // R9 early true-leg drive before lock
    chk("R9", {dt_oe, dt_out, dc_oe, se_out}, 8'b11_11_00_00);
    pll_lock = 1'b1;
    check_running("R10");

    // R4 a single-edge pulse is ignored
    pd_pin = 1'b1;
    @(negedge ref_c);
    pd_pin = 1'b0;
    repeat (20) @(negedge ref_c);
    chk("R4", osc_stop, 0);
    chk("R4", dc_oe, 2'b11);

    for (int k = 0; k < 4; k++) begin
      drive_mode = VEC[k][7:6];
      repeat (3) @(negedge ref_c);
      t_pk0 = -1; t_pk1 = -1;
      pd_pin = 1'b1;
      @(posedge ref_c);
      @(posedge ref_c);
      t_acc = $realtime;
      wait_stop(1'b1, ok);
      chk("R4", ok, 1);
      chk("R8", {se_out, dc_oe}, 0);
      chk("R5", se_out, 0);
      chk("R7", {dt_oe, dt_out, dc_oe}, VEC[k][5:0]);
      chk_max("R6", t_pk0, 64);
      chk_max("R6", t_pk1, 96);
      pll_lock = 1'b0;
      repeat (3) @(negedge ref_c);
      chk("R8", osc_stop, 1);
      pd_pin = 1'b0;
      wait_stop(1'b0, ok);
      chk("R9", ok, 1);
      repeat (3) @(negedge ref_c);
      chk("R9", {dt_oe, dt_out, dc_oe, se_out}, 8'b11_11_00_00);
      pll_lock = 1'b1;
      check_running("R10");
    end

    chk("R5", runt, 0);

    // R1 reset asserted mid-run
    @(negedge ref_c);
    rst_n = 1'b0;
    #1;
    chk("R1", {se_out, dt_out, dt_oe, dc_out, dc_oe}, 0);
    chk("R1", {strap_q, osc_stop}, 0);
    finish_run();
  end

endmodule